// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block holds the link-integrity state of a 10 Mb/s twisted-pair transceiver. It keeps one of two states, link good or link failed. Its inputs are a one-cycle strobe for each link test pulse the receive path detects, and a level that is high while the receive path sees packet carrier.

The block gates the transmit enable that goes to the line driver. It also gates delivery of received packets to the MAC. Time is counted in ticks of `tick_i`, which is normally a 1 ms strobe. All time limits and the pulse run length are parameters given in ticks. With a 1 ms tick, the link-loss limit should be set between 50 and 150. The minimum pulse spacing should be set between 2 and 7. The maximum pulse spacing should be set between 25 and 150.

A failed link recovers in one of two ways: after an unbroken run of correctly spaced pulses, or on the arrival of receive carrier. The packet whose carrier revives the link is never delivered. When the auto-negotiation mode input is set, carrier cannot revive the link.

Top module: `link_integrity_mon`

## Requirements
- R1: In the good state, the block enters the failed state at the tick where LOSS_TICKS ticks have elapsed with neither a pulse strobe nor receive carrier. Counting starts from the cycle after the last such event. A pulse or carrier sampled in that same tick keeps the link good.
- R2: The spacing of a pulse is the number of ticks from the cycle after the previous pulse up to and including its own cycle. A pulse is valid only when its spacing lies in [GAP_MIN, GAP_MAX]. The first pulse after reset is never valid.
- R3: Pulses spaced below GAP_MIN or above GAP_MAX never move the block out of the failed state, however many arrive.
- R4: In the failed state, an invalid pulse clears the run of valid pulses and becomes the new spacing reference. The RUN_LEN-th consecutive valid pulse moves the block to the good state. Without a pulse or carrier, the failed state persists.
- R5: `tx_en_o` equals `tx_req_i` in the good state and is 0 in the failed state.
- R6: With `an_mode_i` low, carrier in the failed state moves the block to the good state on the next cycle. `rx_accept_o` stays 0 for the whole of that packet. A later packet, arriving after carrier has been low for at least one cycle, is accepted (`rx_accept_o` = `rx_act_i`).
- R7: With `an_mode_i` high, carrier in the failed state does not change the state. Only valid pulses can move the block to the good state.
- R8: While `rst_ni` is low, the block is in the failed state with all timers and counters cleared. `link_ok_o`, `tx_en_o`, `rx_accept_o` and both event outputs are 0.
- R9: `pass_evt_o` and `fail_evt_o` are each high for exactly the first cycle of the new state after a transition, and are never high together.
- R10: Timers advance only on cycles where `tick_i` is high. With `tick_i` held low, the link never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe, one tick per time unit |
| an_mode_i | input | 1 | Auto-negotiation mode; blocks carrier-based recovery |
| ltp_i | input | 1 | One-cycle strobe per detected link test pulse |
| rx_act_i | input | 1 | Receive carrier present |
| tx_req_i | input | 1 | MAC transmit request |
| link_ok_o | output | 1 | 1 in the good state |
| tx_en_o | output | 1 | Gated transmit enable |
| rx_accept_o | output | 1 | Receive data may be delivered to the MAC |
| pass_evt_o | output | 1 | One-cycle event on entry to the good state |
| fail_evt_o | output | 1 | One-cycle event on entry to the failed state |

## Verification
The link-loss expiry and a keep-alive event can land on the same tick. The bench provokes this by placing a pulse exactly LOSS_TICKS ticks after the last activity. It then repeats the case with a one-cycle carrier burst at that same offset. In both cases the link must stay good, and a quiet interval one tick longer must fail it on exactly that tick.

A second coincidence occurs when a carrier-driven revival meets the start of a packet. The bench judges it by requiring that the link becomes good while `rx_accept_o` stays low for the whole reviving packet.

// File: rtl/link_integrity_pkg.sv
package link_integrity_pkg;
  typedef enum logic {
    LS_FAIL = 1'b0,
    LS_PASS = 1'b1
  } link_state_e;
endpackage

// File: rtl/lim_interval.sv
// Saturating tick counter; elapsed_o includes the tick of the current cycle.
module lim_interval #(
  parameter int LIMIT = 100
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         clr_i,
  output logic [$clog2(LIMIT+2)-1:0]   elapsed_o
);
  localparam int W = $clog2(LIMIT + 2);

  logic [W-1:0] cnt_q;

  always_comb begin
    if (tick_i && (cnt_q < W'(LIMIT))) elapsed_o = cnt_q + 1'b1;
    else                               elapsed_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= elapsed_o;
  end
endmodule

// File: rtl/lim_pulse_qual.sv
// Classifies each pulse strobe by its spacing from the previous one.
module lim_pulse_qual #(
  parameter int GAP_MIN = 4,
  parameter int GAP_MAX = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ltp_i,
  output logic valid_o,
  output logic invalid_o
);
  localparam int LIM = GAP_MAX + 1;
  localparam int W   = $clog2(LIM + 2);

  logic [W-1:0] gap;
  logic         have_ref_q;
  logic         in_window;

  lim_interval #(.LIMIT(LIM)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clr_i    (ltp_i),
    .elapsed_o(gap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    have_ref_q <= 1'b0;
    else if (ltp_i) have_ref_q <= 1'b1;
  end

  assign in_window = (gap >= W'(GAP_MIN)) && (gap <= W'(GAP_MAX));
  assign valid_o   = ltp_i && have_ref_q && in_window;
  assign invalid_o = ltp_i && !valid_o;
endmodule

// File: rtl/lim_run_count.sv
// Counts consecutive valid pulses; done_o on the one completing the run.
module lim_run_count #(
  parameter int RUN_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int W = $clog2(RUN_LEN + 1);

  logic [W-1:0] cnt_q;

  assign done_o = inc_i && !clr_i && (cnt_q == W'(RUN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || done_o)    cnt_q <= '0;
    else if (inc_i)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lim_state.sv
module lim_state
  import link_integrity_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_done_i,
  input  logic carrier_i,
  input  logic an_mode_i,
  input  logic expire_i,
  output logic pass_o,
  output logic drop_o,
  output logic pass_evt_o,
  output logic fail_evt_o
);
  link_state_e state_q;
  logic        go_pass, go_fail;
  logic        drop_q, pass_evt_q, fail_evt_q;

  assign go_pass = (state_q == LS_FAIL) && (run_done_i || (carrier_i && !an_mode_i));
  assign go_fail = (state_q == LS_PASS) && expire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= LS_FAIL;
      pass_evt_q <= 1'b0;
      fail_evt_q <= 1'b0;
      drop_q     <= 1'b0;
    end else begin
      pass_evt_q <= go_pass;
      fail_evt_q <= go_fail;
      if (go_pass)      state_q <= LS_PASS;
      else if (go_fail) state_q <= LS_FAIL;
      // a packet seen in the failed state is discarded until carrier drops
      if (state_q == LS_FAIL && carrier_i) drop_q <= 1'b1;
      else if (!carrier_i)                 drop_q <= 1'b0;
    end
  end

  assign pass_o     = (state_q == LS_PASS);
  assign drop_o     = drop_q;
  assign pass_evt_o = pass_evt_q;
  assign fail_evt_o = fail_evt_q;
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int LOSS_TICKS = 100,
  parameter int GAP_MIN    = 4,
  parameter int GAP_MAX    = 100,
  parameter int RUN_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic an_mode_i,
  input  logic ltp_i,
  input  logic rx_act_i,
  input  logic tx_req_i,
  output logic link_ok_o,
  output logic tx_en_o,
  output logic rx_accept_o,
  output logic pass_evt_o,
  output logic fail_evt_o
);
  localparam int LW = $clog2(LOSS_TICKS + 2);

  logic          pulse_ok, pulse_bad, run_done;
  logic          pass, drop, activity, expire;
  logic [LW-1:0] quiet;

  assign activity = ltp_i || rx_act_i;

  lim_pulse_qual #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ltp_i    (ltp_i),
    .valid_o  (pulse_ok),
    .invalid_o(pulse_bad)
  );

  lim_run_count #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (pulse_ok),
    .clr_i (pulse_bad || pass),
    .done_o(run_done)
  );

  lim_interval #(.LIMIT(LOSS_TICKS)) u_loss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clr_i    (activity || !pass),
    .elapsed_o(quiet)
  );

  assign expire = pass && !activity && (quiet == LW'(LOSS_TICKS));

  lim_state u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_done_i(run_done),
    .carrier_i (rx_act_i),
    .an_mode_i (an_mode_i),
    .expire_i  (expire),
    .pass_o    (pass),
    .drop_o    (drop),
    .pass_evt_o(pass_evt_o),
    .fail_evt_o(fail_evt_o)
  );

  assign link_ok_o   = pass;
  assign tx_en_o     = tx_req_i && pass;
  assign rx_accept_o = rx_act_i && pass && !drop;
endmodule

// File: rtl/link_integrity_chk.sv
module link_integrity_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic an_mode_i,
  input logic ltp_i,
  input logic rx_act_i,
  input logic tx_req_i,
  input logic link_ok_o,
  input logic tx_en_o,
  input logic rx_accept_o,
  input logic pass_evt_o,
  input logic fail_evt_o
);
  AST_ACTIVITY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_o && (ltp_i || rx_act_i)) |=> link_ok_o); // R1
  AST_QUIET_FAIL_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_ok_o && !ltp_i && !rx_act_i) |=> !link_ok_o); // R4
  AST_TX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> (tx_req_i && link_ok_o)); // R5
  AST_REVIVE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_ok_o && rx_act_i) |=> !rx_accept_o); // R6
  AST_ACCEPT_NEEDS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_accept_o |-> (link_ok_o && rx_act_i)); // R6
  AST_AN_NO_CARRIER_REVIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_ok_o && an_mode_i && !ltp_i) |=> !link_ok_o); // R7
  AST_PASS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ok_o) |-> pass_evt_o); // R9
  AST_FAIL_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_ok_o) |-> fail_evt_o); // R9
  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pass_evt_o, fail_evt_o})); // R9
  AST_NO_TICK_NO_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_o && !tick_i) |=> link_ok_o); // R10
endmodule

bind link_integrity_mon link_integrity_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .an_mode_i  (an_mode_i),
  .ltp_i      (ltp_i),
  .rx_act_i   (rx_act_i),
  .tx_req_i   (tx_req_i),
  .link_ok_o  (link_ok_o),
  .tx_en_o    (tx_en_o),
  .rx_accept_o(rx_accept_o),
  .pass_evt_o (pass_evt_o),
  .fail_evt_o (fail_evt_o)
);

// File: tb/sim_link_integrity_mon.sv
`timescale 1ns/1ps
module sim_link_integrity_mon;
  localparam int LOSS = 100;
  localparam int GMIN = 4;
  localparam int GMAX = 100;
  localparam int RUN  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic an_mode_i = 1'b0;
  logic ltp_i = 1'b0;
  logic rx_act_i = 1'b0;
  logic tx_req_i = 1'b0;
  logic link_ok_o, tx_en_o, rx_accept_o, pass_evt_o, fail_evt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  link_integrity_mon #(
    .LOSS_TICKS(LOSS), .GAP_MIN(GMIN), .GAP_MAX(GMAX), .RUN_LEN(RUN)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .an_mode_i(an_mode_i),
    .ltp_i(ltp_i), .rx_act_i(rx_act_i), .tx_req_i(tx_req_i),
    .link_ok_o(link_ok_o), .tx_en_o(tx_en_o), .rx_accept_o(rx_accept_o),
    .pass_evt_o(pass_evt_o), .fail_evt_o(fail_evt_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // pulse sampled exactly d ticks after the previous one
  task automatic pulse(input int d);
    repeat (d - 1) @(negedge clk_i);
    ltp_i = 1'b1;
    @(negedge clk_i);
    ltp_i = 1'b0;
  endtask

  task automatic reach_pass_by_pulses();
    pulse(GMAX + 1); // reference (invalid spacing)
    for (int i = 0; i < RUN; i++) pulse(GMIN);
  endtask

  initial begin
    tx_req_i = 1'b1;
    step(3);
    #1;
    check("R8 link in reset", link_ok_o, 1'b0);
    check("R8 tx_en in reset", tx_en_o, 1'b0);
    check("R8 rx_accept in reset", rx_accept_o, 1'b0);
    check("R8 events in reset", pass_evt_o | fail_evt_o, 1'b0);
    rst_ni = 1'b1;
    step(2);
    check("R8 fail after reset", link_ok_o, 1'b0);

    // R2 R4: first pulse is reference only; RUN valid pulses needed
    pulse(10);
    for (int i = 1; i < RUN; i++) begin
      pulse(10);
      check("R4 run incomplete", link_ok_o, 1'b0);
    end
    pulse(10);
    check("R4 run complete", link_ok_o, 1'b1);
    check("R9 pass_evt", pass_evt_o, 1'b1);
    check("R5 tx_en in pass", tx_en_o, 1'b1);
    step(1);
    check("R9 pass_evt one cycle", pass_evt_o, 1'b0);

    // R1 loss: fails exactly LOSS ticks after the last pulse
    step(LOSS - 2);
    check("R1 not yet expired", link_ok_o, 1'b1);
    step(1);
    check("R1 expired", link_ok_o, 1'b0);
    check("R9 fail_evt", fail_evt_o, 1'b1);
    check("R5 tx_en in fail", tx_en_o, 1'b0);
    step(1);
    check("R9 fail_evt one cycle", fail_evt_o, 1'b0);

    // R2 R3: sweep spacings around both limits
    for (int s = 1; s < GMIN; s++) begin
      for (int k = 0; k < 2 * RUN; k++) pulse(s);
      check("R3 short spacing stays fail", link_ok_o, 1'b0);
    end
    for (int s = GMAX + 1; s <= GMAX + 3; s++) begin
      for (int k = 0; k < RUN + 1; k++) pulse(s);
      check("R3 long spacing stays fail", link_ok_o, 1'b0);
    end

    // R4: invalid pulse breaks the run and becomes reference
    for (int k = 0; k < RUN - 1; k++) pulse(GMIN);
    check("R4 partial run", link_ok_o, 1'b0);
    pulse(GMIN - 1);
    for (int k = 0; k < RUN - 1; k++) pulse(GMAX);
    check("R4 run restarted", link_ok_o, 1'b0);
    pulse(GMAX);
    check("R2 spacing at max valid", link_ok_o, 1'b1);

    // R1 same-tick keep-alive: pulse in the expiring tick
    pulse(LOSS);
    check("R1 pulse at expiry holds", link_ok_o, 1'b1);
    step(LOSS - 1);
    rx_act_i = 1'b1;
    #1;
    check("R6 accept in pass", rx_accept_o, 1'b1);
    @(negedge clk_i);
    rx_act_i = 1'b0;
    check("R1 carrier at expiry holds", link_ok_o, 1'b1);

    // R1: carrier restarts the timer
    rx_act_i = 1'b1;
    step(3 * LOSS);
    check("R1 carrier keeps pass", link_ok_o, 1'b1);
    check("R6 long packet accepted", rx_accept_o, 1'b1);
    rx_act_i = 1'b0;
    step(LOSS - 1);
    check("R1 after carrier not expired", link_ok_o, 1'b1);
    step(1);
    check("R1 after carrier expired", link_ok_o, 1'b0);

    // R6 revival by carrier, that packet dropped
    step(5);
    rx_act_i = 1'b1;
    #1;
    check("R6 revive cycle no accept", rx_accept_o, 1'b0);
    @(negedge clk_i);
    check("R6 revived", link_ok_o, 1'b1);
    check("R9 pass_evt on revive", pass_evt_o, 1'b1);
    begin
      int acc = 0;
      for (int k = 0; k < 40; k++) begin
        #1;
        acc += int'(rx_accept_o);
        @(negedge clk_i);
      end
      check("R6 reviving packet dropped", acc == 0, 1'b1);
    end
    rx_act_i = 1'b0;
    step(2);
    rx_act_i = 1'b1;
    #1;
    check("R6 next packet accepted", rx_accept_o, 1'b1);
    @(negedge clk_i);
    rx_act_i = 1'b0;

    // R7 auto-negotiation mode
    step(LOSS);
    check("R7 pre: failed", link_ok_o, 1'b0);
    an_mode_i = 1'b1;
    rx_act_i = 1'b1;
    step(50);
    check("R7 carrier no revive", link_ok_o, 1'b0);
    check("R7 no accept in fail", rx_accept_o, 1'b0);
    rx_act_i = 1'b0;
    reach_pass_by_pulses();
    check("R7 pulses revive", link_ok_o, 1'b1);
    an_mode_i = 1'b0;

    // R10 tick gating
    tick_i = 1'b0;
    step(3 * LOSS);
    check("R10 no tick no loss", link_ok_o, 1'b1);
    tick_i = 1'b1;
    step(LOSS - 1);
    check("R10 ticks resume", link_ok_o, 1'b1);
    step(1);
    check("R10 expiry after resumed ticks", link_ok_o, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule